// File: doc/BRIEF.md
# CPU-to-Expansion-Bus Address Translator

This block sits between a 24-bit CPU request/acknowledge bus and two targets: a slow 20-bit expansion bus and fast on-board RAM. For each request it decides where the access goes. It can go to the expansion bus, to on-board RAM, or to both. It also works out the expansion address to drive. Some windows are moved to a different expansion address and some keep their address. Each window has its own rule for which directions are allowed.

The two legacy screen windows are shadow windows. A write goes to on-board RAM and is also copied out to the expansion bus. A read is served only from on-board RAM. The copy-out for the second screen can be turned off by a control input. A write to a read-only window makes no strobe at all, but it is still acknowledged so the CPU never stalls. Any address outside the listed windows goes to on-board RAM alone.

The CPU holds `cpu_req` and the other request signals steady until it sees `cpu_ack`. It drops `cpu_req` during the single acknowledge cycle. On-board RAM takes one strobe cycle. An expansion strobe stays high until `exp_rdy` is seen.

Top module: `addr_xlat_bridge`

## Requirements
- R1: CPU addresses 0x4C0000..0x4FFFFF reach the expansion bus at 0xC0000..0xFFFFF (CPU address minus 0x400000). Both reads and writes are allowed, and on-board RAM is not touched.
- R2: Screen window A is 0x20000..0x27FFF. A write strobes on-board RAM at the CPU address and then the expansion bus at the same address. A read strobes only on-board RAM.
- R3: Screen window B is 0x28000..0x2FFFF and behaves like window A while `scr1_wt_off` is 0. While `scr1_wt_off` is 1 (sampled with the request), a write goes to on-board RAM only and is acknowledged right after the RAM strobe.
- R4: CPU addresses 0x18000..0x1BFFF pass to the expansion bus at the same address, for both reads and writes.
- R5: CPU addresses 0xC000..0xFFFF pass to the expansion bus at the same address for reads only. A write there raises no strobe of any kind and is still acknowledged.
- R6: CPU addresses 0x400000..0x40FFFF map to expansion addresses 0x0000..0xFFFF for reads only. A write there raises no strobe and is still acknowledged.
- R7: Any other address strobes only on-board RAM, at the CPU address, and never drives an expansion strobe.
- R8: An expansion strobe stays asserted until `exp_rdy` is sampled high. Any access that uses the expansion bus is acknowledged only after that.
- R9: After reset, all strobes and `cpu_ack` are low.
- R10: Each request gets exactly one single-cycle `cpu_ack`. At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | CPU byte address |
| scr1_wt_off | input | 1 | Disables expansion copy-out for screen window B |
| cpu_ack | output | 1 | One-cycle completion pulse |
| ram_rd | output | 1 | On-board RAM read strobe |
| ram_wr | output | 1 | On-board RAM write strobe |
| ram_addr | output | 24 | On-board RAM address |
| exp_rdy | input | 1 | Expansion bus completion |
| exp_rd | output | 1 | Expansion read strobe |
| exp_wr | output | 1 | Expansion write strobe |
| exp_addr | output | 20 | Translated expansion address |

## Verification
The bench builds the block with the package widths: a 24-bit CPU address and a 20-bit expansion address. At these widths all six windows and their exact edges can be reached. Random expansion ready delays of zero to six cycles test the rule that the acknowledge waits for the ready, both when the ready comes at once and when it is held off. Directed requests sit one byte either side of every window boundary. Writes to the read-only windows and to screen window B are repeated with the control input in both states.

// File: rtl/axl_pkg.sv
package axl_pkg;
    localparam int CPU_AW = 24;
    localparam int EXP_AW = 20;

    typedef enum logic [2:0] {
        RG_LOCAL, RG_EXPHI, RG_ROMHI, RG_SCRA, RG_SCRB, RG_IO, RG_SLOT
    } region_e;

    typedef struct packed {
        region_e             rgn;
        logic                ext_go;   // touches expansion bus
        logic                ram_go;   // touches on-board RAM
        logic                we;
        logic [EXP_AW-1:0]   xaddr;
    } route_t;

    function automatic logic in_win(logic [CPU_AW-1:0] a,
                                    logic [CPU_AW-1:0] lo,
                                    logic [CPU_AW-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic region_e classify(logic [CPU_AW-1:0] a);
        if (in_win(a, 24'h4C0000, 24'h4FFFFF)) return RG_EXPHI;
        if (in_win(a, 24'h400000, 24'h40FFFF)) return RG_ROMHI;
        if (in_win(a, 24'h020000, 24'h027FFF)) return RG_SCRA;
        if (in_win(a, 24'h028000, 24'h02FFFF)) return RG_SCRB;
        if (in_win(a, 24'h018000, 24'h01BFFF)) return RG_IO;
        if (in_win(a, 24'h00C000, 24'h00FFFF)) return RG_SLOT;
        return RG_LOCAL;
    endfunction
endpackage

// File: rtl/axl_decode.sv
module axl_decode
    import axl_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    input  logic              we,
    input  logic              scrb_off,
    output route_t            route
);
    region_e rg;
    logic    ro_win;

    always_comb begin
        rg     = classify(addr);
        ro_win = (rg == RG_ROMHI) || (rg == RG_SLOT);
        route.rgn    = rg;
        route.we     = we;
        route.xaddr  = (rg == RG_ROMHI) ? EXP_AW'(addr[15:0]) : addr[EXP_AW-1:0];
        route.ram_go = (rg == RG_LOCAL) || (rg == RG_SCRA) || (rg == RG_SCRB);
        unique case (rg)
            RG_EXPHI, RG_IO:  route.ext_go = 1'b1;
            RG_ROMHI, RG_SLOT: route.ext_go = !we;
            RG_SCRA:          route.ext_go = we;
            RG_SCRB:          route.ext_go = we && !scrb_off;
            default:          route.ext_go = 1'b0;
        endcase
        if (ro_win && we) route.ext_go = 1'b0;
    end
endmodule

// File: rtl/axl_seq.sv
module axl_seq
    import axl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [CPU_AW-1:0] addr,
    input  route_t            route_in,
    input  logic              exp_rdy,
    output logic              ack,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [CPU_AW-1:0] ram_addr,
    output logic              exp_rd,
    output logic              exp_wr,
    output logic [EXP_AW-1:0] exp_addr
);
    typedef enum logic [1:0] {S_IDLE, S_RAM, S_EXT, S_ACK} state_e;
    state_e            st;
    route_t            lat;
    logic [CPU_AW-1:0] lat_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            lat      <= '0;
            lat_addr <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (req) begin
                    lat      <= route_in;
                    lat_addr <= addr;
                    if (route_in.ram_go)      st <= S_RAM;
                    else if (route_in.ext_go) st <= S_EXT;
                    else                      st <= S_ACK;
                end
                S_RAM:  st <= lat.ext_go ? S_EXT : S_ACK;
                S_EXT:  if (exp_rdy) st <= S_ACK;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        ack      = (st == S_ACK);
        ram_rd   = (st == S_RAM) && !lat.we;
        ram_wr   = (st == S_RAM) &&  lat.we;
        exp_rd   = (st == S_EXT) && !lat.we;
        exp_wr   = (st == S_EXT) &&  lat.we;
        exp_addr = (st == S_EXT) ? lat.xaddr : '0;
        ram_addr = lat_addr;
    end

    p_no_wr_readonly_r5: assert property (@(posedge clk) disable iff (rst)
        exp_wr |-> !(lat.rgn == RG_ROMHI || lat.rgn == RG_SLOT));
    p_no_wr_romhi_r6: assert property (@(posedge clk) disable iff (rst)
        (ram_rd || ram_wr) |-> (lat.rgn != RG_ROMHI));
    p_local_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (exp_rd || exp_wr) |-> (lat.rgn != RG_LOCAL));
    p_strobe_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ((exp_rd || exp_wr) && !exp_rdy) |=> (exp_rd || exp_wr));
    p_ack_after_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && lat.ext_go) |-> $past(exp_rdy));
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_rd, ram_wr, exp_rd, exp_wr}));
endmodule

// File: rtl/addr_xlat_bridge.sv
module addr_xlat_bridge
    import axl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              scr1_wt_off,
    output logic              cpu_ack,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [CPU_AW-1:0] ram_addr,
    input  logic              exp_rdy,
    output logic              exp_rd,
    output logic              exp_wr,
    output logic [EXP_AW-1:0] exp_addr
);
    route_t route;

    axl_decode u_dec (
        .addr     (cpu_addr),
        .we       (cpu_we),
        .scrb_off (scr1_wt_off),
        .route    (route)
    );

    axl_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (cpu_req),
        .addr     (cpu_addr),
        .route_in (route),
        .exp_rdy  (exp_rdy),
        .ack      (cpu_ack),
        .ram_rd   (ram_rd),
        .ram_wr   (ram_wr),
        .ram_addr (ram_addr),
        .exp_rd   (exp_rd),
        .exp_wr   (exp_wr),
        .exp_addr (exp_addr)
    );

    p_reset_quiet_r9: assert property (@(posedge clk)
        $past(rst) |-> !(cpu_ack || ram_rd || ram_wr || exp_rd || exp_wr));
endmodule

// File: tb/addr_xlat_bridge_tb_top.sv
module addr_xlat_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, scr1_wt_off = 1'b0, exp_rdy = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_ack, ram_rd, ram_wr, exp_rd, exp_wr;
    logic [23:0] ram_addr;
    logic [19:0] exp_addr;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    addr_xlat_bridge dut_i (.*);

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model(logic [23:0] a, logic w, logic off);
        // returns {ext_rd, ext_wr, ram_rd, ram_wr, xaddr[19:0]}
        logic [3:0]  s;
        logic [19:0] x;
        x = a[19:0];
        if (a >= 24'h4C0000 && a <= 24'h4FFFFF)      begin s = w ? 4'b0100 : 4'b1000; x = 20'(a - 24'h400000); end
        else if (a >= 24'h400000 && a <= 24'h40FFFF) begin s = w ? 4'b0000 : 4'b1000; x = 20'(a - 24'h400000); end
        else if (a >= 24'h020000 && a <= 24'h027FFF)  s = w ? 4'b0101 : 4'b0010;
        else if (a >= 24'h028000 && a <= 24'h02FFFF)  s = w ? (off ? 4'b0001 : 4'b0101) : 4'b0010;
        else if (a >= 24'h018000 && a <= 24'h01BFFF)  s = w ? 4'b0100 : 4'b1000;
        else if (a >= 24'h00C000 && a <= 24'h00FFFF)  s = w ? 4'b0000 : 4'b1000;
        else                                          s = w ? 4'b0001 : 4'b0010;
        return {s, x};
    endfunction

    function automatic string tag(logic [23:0] a);
        if (a >= 24'h4C0000 && a <= 24'h4FFFFF) return "R1";
        if (a >= 24'h400000 && a <= 24'h40FFFF) return "R6";
        if (a >= 24'h020000 && a <= 24'h027FFF) return "R2";
        if (a >= 24'h028000 && a <= 24'h02FFFF) return "R3";
        if (a >= 24'h018000 && a <= 24'h01BFFF) return "R4";
        if (a >= 24'h00C000 && a <= 24'h00FFFF) return "R5";
        return "R7";
    endfunction

    task automatic access(logic [23:0] a, logic w, logic off, int dly);
        logic [23:0] m;
        logic [3:0]  seen;
        logic [19:0] xa;
        logic [23:0] ra;
        int          cnt;
        bit          got, rdy_given, early;
        string       t;
        m = model(a, w, off); t = tag(a);
        seen = '0; xa = '0; ra = '0; cnt = 0; got = 0; rdy_given = 0; early = 0;
        @(negedge clk);
        cpu_addr = a; cpu_we = w; scr1_wt_off = off; cpu_req = 1'b1;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (exp_rd) seen[3] = 1'b1;
            if (exp_wr) seen[2] = 1'b1;
            if (ram_rd) seen[1] = 1'b1;
            if (ram_wr) seen[0] = 1'b1;
            if (exp_rd || exp_wr) begin xa = exp_addr; cnt++; end
            if (ram_rd || ram_wr) ra = ram_addr;
            if (cpu_ack) begin
                got = 1; early = !rdy_given;
                cpu_req = 1'b0; exp_rdy = 1'b0;
                break;
            end
            exp_rdy = (exp_rd || exp_wr) && (cnt > dly);
            if (exp_rdy) rdy_given = 1;
        end
        chk(got, "R10 ack", 32'(got), 1);
        chk(seen == m[23:20], {t, " strobes"}, 32'(seen), 32'(m[23:20]));
        if (m[23:22] != 0) begin
            chk(xa == m[19:0], {t, " exp_addr"}, 32'(xa), 32'(m[19:0]));
            chk(!early, "R8 ack before ready", 32'(early), 0);
        end
        if (m[21:20] != 0)
            chk(ra == a, {t, " ram_addr"}, 32'(ra), 32'(a));
        @(negedge clk);
        chk(!cpu_ack, "R10 single ack", 32'(cpu_ack), 0);
    endtask

    initial begin
        for (int i = 0; i < 40000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog act=hung exp=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [23:0] edges [26];
        logic [23:0] base [7];
        logic [23:0] span [7];
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!(cpu_ack || ram_rd || ram_wr || exp_rd || exp_wr), "R9 reset",
            32'({cpu_ack, ram_rd, ram_wr, exp_rd, exp_wr}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!(cpu_ack || ram_rd || ram_wr || exp_rd || exp_wr), "R9 idle",
            32'({cpu_ack, ram_rd, ram_wr, exp_rd, exp_wr}), 0);

        edges = '{24'h4BFFFF, 24'h4C0000, 24'h4FFFFF, 24'h500000, 24'h3FFFFF,
                  24'h400000, 24'h40FFFF, 24'h410000, 24'h01FFFF, 24'h020000,
                  24'h027FFF, 24'h028000, 24'h02FFFF, 24'h030000, 24'h017FFF,
                  24'h018000, 24'h01BFFF, 24'h01C000, 24'h00BFFF, 24'h00C000,
                  24'h00FFFF, 24'h010000, 24'h000000, 24'hFFFFFF, 24'h4C1234, 24'h00C100};
        foreach (edges[i])
            for (int w = 0; w < 2; w++)
                for (int o = 0; o < 2; o++)
                    access(edges[i], w[0], o[0], (i + w) % 4);

        base = '{24'h4C0000, 24'h400000, 24'h020000, 24'h028000, 24'h018000, 24'h00C000, 24'h100000};
        span = '{24'h40000, 24'h10000, 24'h8000, 24'h8000, 24'h4000, 24'h4000, 24'h300000};
        for (int k = 0; k < 300; k++) begin
            int r;
            r = int'($urandom_range(0, 6));
            access(base[r] + 24'($urandom_range(0, int'(span[r]) - 1)),
                   1'($urandom), 1'($urandom), int'($urandom_range(0, 6)));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule